// File: doc/BRIEF.md
# Pipelined No-Wait-State Burst SRAM

This block is a synchronous static memory with registered address, control and data paths. Reads and writes travel down one shared two-stage pipeline. A read returns its word two clock edges after it is issued. A write takes its data from the input bus two edges after it is issued. Because both directions have the same delay, any mix of reads and writes can be issued on consecutive clocks with no turnaround gap.

Each access either loads a new external address or advances an internal two-bit burst counter. The counter steps through a four-word group, in either interleaved or linear order, while the upper address bits stay fixed. Three chip enables qualify every load. Per-lane byte write enables mask writes, and each lane holds 8 data bits plus one parity bit.

A low-active clock enable freezes every register of the access path. The output enable masks the valid flag at once, without waiting for a clock edge. A sleep request shuts the access path down and brings it back on fixed cycle counts. The tri-state data pins are replaced by separate input and output buses and an output-valid flag.

Top module: `nws_sram`

## Requirements
- R1: A selected load (`adv_i`=0) with `we_ni`=1 at edge N drives the addressed word on `rdata_o` with `rvalid_o`=1 after edge N+2. A selected load with `we_ni`=0 at edge N writes the `wdata_i` value present at edge N+2. Reads and writes may alternate on every edge.
- R2: A load is selected only when `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0. Any other combination makes the cycle a deselect: it performs no access, and its pipeline slot leaves `rvalid_o` low.
- R3: With `adv_i`=1 after a selected load, the next burst word is accessed. The operation type (read or write) is kept and address bits above bit 1 stay fixed. With `adv_i`=1 after a deselect, the block stays deselected.
- R4: With `mode_i`=1, the k-th word of a burst (k=0..3) uses address bits [1:0] = start XOR k.
- R5: With `mode_i`=0, the k-th word uses address bits [1:0] = (start + k) mod 4. In both modes a burst that is advanced more than three times wraps around the same four words.
- R6: Byte lane i is bits [9i+8:9i] of the word and is written only when `bw_ni[i]`=0. With `bw_ni` all ones, a write cycle leaves the array unchanged.
- R7: A read issued on the edge right after a write to the same address returns the newly written lanes merged with the unwritten old lanes.
- R8: While `cke_ni`=1, every command, address and data input is ignored, and all pipeline, burst and output registers keep their values.
- R9: `oe_ni`=1 forces `rvalid_o` low in the same cycle without disturbing the pipeline.
- R10: If `sleep_i` is high at edge E, the command inputs at edge E+2 are ignored, and `rvalid_o` is low after edge E+1 until the request clears. The first command accepted after release is the one at the second edge after `sleep_i` is first seen low. The sleep sequencing counts every edge, whether or not the clock is enabled.
- R11: After reset, `rvalid_o` is low and every array word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Word address, sampled on loads |
| adv_i | input | 1 | 1 = advance burst, 0 = load new address |
| we_ni | input | 1 | Write enable, active low, sampled on loads |
| bw_ni | input | LANES | Byte-lane write enables, active low, sampled every cycle |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| cke_ni | input | 1 | Clock enable, active low |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| sleep_i | input | 1 | Sleep request, active high |
| mode_i | input | 1 | Burst order: 1 interleaved, 0 linear |
| wdata_i | input | LANES*LANE_W | Write data, taken two edges after the write is issued |
| rdata_o | output | LANES*LANE_W | Registered read data |
| rvalid_o | output | 1 | Read data valid |

## Verification
The bench targets a read placed right behind a partial write to the same word. A design that committed late-write data after the array read would return stale lanes there. It also runs bursts from every starting offset in both orders and past the fourth word, which exposes a counter that saturates, or that uses one order's sequence in place of the other's. Clock-enable stalls are inserted in the middle of bursts and pipelines while junk commands are driven. This catches a pipeline stage or the write-data capture that keeps moving during the stall. Sleep is entered with writes issued while asleep: a design with the wrong edge count would either drop the last legal reads or let an ignored write reach the array.

// File: rtl/nws_sram_pkg.sv
`timescale 1ns/1ps
package nws_sram_pkg;
  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_READ = 2'd1, OP_WRITE = 2'd2} op_e;

  // burst word k from a starting offset; ilv selects xor order
  function automatic logic [1:0] burst_lsb(logic [1:0] start, logic [1:0] k, logic ilv);
    return ilv ? (start ^ k) : (start + k);
  endfunction
endpackage

// File: rtl/nws_sram_ctrl.sv
`timescale 1ns/1ps
module nws_sram_ctrl
  import nws_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic              sleep_i,
  input  logic              adv_i,
  input  logic              we_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic              ce1_ni,
  input  logic              ce2_i,
  input  logic              ce3_ni,
  input  logic              mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  bw_o,
  output logic              asleep_o
);
  logic [1:0]        slp_q;
  logic              act_q;
  logic [1:0]        start_q, cnt_q, cnt_nx;
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  bw_q;
  logic              sel;

  assign sel    = ~ce1_ni & ce2_i & ~ce3_ni;
  assign cnt_nx = cnt_q + 2'd1;

  // sleep sequencer counts every edge, independent of clock enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) slp_q <= 2'b00;
    else         slp_q <= {slp_q[0], sleep_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q   <= 1'b0;
      op_q    <= OP_IDLE;
      start_q <= 2'd0;
      cnt_q   <= 2'd0;
      addr_q  <= '0;
      bw_q    <= '1;
    end else if (take_i) begin
      if (slp_q[1]) begin
        act_q <= 1'b0;
        op_q  <= OP_IDLE;
      end else if (!adv_i) begin
        act_q   <= sel;
        op_q    <= !sel ? OP_IDLE : (we_ni ? OP_READ : OP_WRITE);
        start_q <= addr_i[1:0];
        cnt_q   <= 2'd0;
        addr_q  <= addr_i;
        bw_q    <= bw_ni;
      end else if (act_q) begin
        cnt_q       <= cnt_nx;
        addr_q[1:0] <= burst_lsb(start_q, cnt_nx, mode_i);
        bw_q        <= bw_ni;
      end else begin
        op_q <= OP_IDLE;
      end
    end
  end

  assign op_o     = op_q;
  assign addr_o   = addr_q;
  assign bw_o     = bw_q;
  assign asleep_o = slp_q[1];

  AST_DESEL_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && adv_i && op_q == OP_IDLE) |=> op_q == OP_IDLE); // R3
  AST_BURST_UPPER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !slp_q[1] && adv_i && op_q != OP_IDLE) |=>
      (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2]) && op_q == $past(op_q))); // R3
  AST_LINEAR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !slp_q[1] && adv_i && op_q != OP_IDLE && !mode_i) |=>
      addr_q[1:0] == $past(addr_q[1:0]) + 2'd1); // R5
  AST_UNSELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !slp_q[1] && !adv_i && (ce1_ni || !ce2_i || ce3_ni)) |=> op_q == OP_IDLE); // R2
  AST_CMD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> ($stable(op_q) && $stable(addr_q) && $stable(bw_q))); // R8
  AST_SLEEP_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && slp_q[1]) |=> op_q == OP_IDLE); // R10
endmodule

// File: rtl/nws_sram_pipe.sv
`timescale 1ns/1ps
module nws_sram_pipe
  import nws_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  op_e               op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANES-1:0]  bw_i,
  output logic              wr_en_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LANES-1:0]  bw_o,
  output logic              rvalid_o
);
  op_e               op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  bw_q;
  logic              rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= OP_IDLE;
      addr_q   <= '0;
      bw_q     <= '1;
      rvalid_q <= 1'b0;
    end else if (take_i) begin
      op_q     <= op_i;
      addr_q   <= addr_i;
      bw_q     <= bw_i;
      rvalid_q <= (op_q == OP_READ);
    end
  end

  // stage-2 commit: writes and reads touch the array in the same stage
  assign wr_en_o  = take_i && (op_q == OP_WRITE);
  assign rd_en_o  = take_i && (op_q == OP_READ);
  assign addr_o   = addr_q;
  assign bw_o     = bw_q;
  assign rvalid_o = rvalid_q;

  AST_PIPE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_i |=> ($stable(rvalid_q) && $stable(op_q) && $stable(addr_q))); // R8
  AST_READ_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && op_q == OP_WRITE) |=> !rvalid_q); // R1
endmodule

// File: rtl/nws_sram_array.sv
`timescale 1ns/1ps
module nws_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic                    rd_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES-1:0]        bw_ni,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] lane_mask;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{~bw_ni[l]}};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en_i) mem_q[addr_i] <= (mem_q[addr_i] & ~lane_mask) | (wdata_i & lane_mask);
      if (rd_en_i) rdata_q <= mem_q[addr_i];
    end
  end

  assign rdata_o = rdata_q;

  AST_ONE_PORT_USE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && rd_en_i)); // R1
endmodule

// File: rtl/nws_sram.sv
`timescale 1ns/1ps
module nws_sram
  import nws_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    adv_i,
  input  logic                    we_ni,
  input  logic [LANES-1:0]        bw_ni,
  input  logic                    ce1_ni,
  input  logic                    ce2_i,
  input  logic                    ce3_ni,
  input  logic                    cke_ni,
  input  logic                    oe_ni,
  input  logic                    sleep_i,
  input  logic                    mode_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  output logic [LANES*LANE_W-1:0] rdata_o,
  output logic                    rvalid_o
);
  logic              take;
  logic              asleep;
  op_e               s1_op;
  logic [ADDR_W-1:0] s1_addr, s2_addr;
  logic [LANES-1:0]  s1_bw, s2_bw;
  logic              wr_en, rd_en, rvalid_q;

  assign take = ~cke_ni;

  nws_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
    .clk_i, .rst_ni, .take_i(take), .sleep_i, .adv_i, .we_ni, .bw_ni,
    .ce1_ni, .ce2_i, .ce3_ni, .mode_i, .addr_i,
    .op_o(s1_op), .addr_o(s1_addr), .bw_o(s1_bw), .asleep_o(asleep)
  );

  nws_sram_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
    .clk_i, .rst_ni, .take_i(take), .op_i(s1_op), .addr_i(s1_addr), .bw_i(s1_bw),
    .wr_en_o(wr_en), .rd_en_o(rd_en), .addr_o(s2_addr), .bw_o(s2_bw), .rvalid_o(rvalid_q)
  );

  nws_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(s2_addr),
    .bw_ni(s2_bw), .wdata_i, .rdata_o
  );

  // output enable acts combinationally; sleep blanks the bus
  assign rvalid_o = rvalid_q & ~oe_ni & ~asleep;

  AST_FROZEN_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> $stable(rdata_o)); // R8
endmodule

// File: tb/nws_sram_tb_top.sv
`timescale 1ns/1ps
module nws_sram_tb_top;
  localparam int AW = 6, LN = 4, LW = 9, DW = LN * LW, DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          adv = 1'b0, we_n = 1'b1, ce1_n = 1'b1, ce2 = 1'b1, ce3_n = 1'b0;
  logic [LN-1:0] bw_n = '1;
  logic          cke_n = 1'b0, oe_n = 1'b0, sleep = 1'b0, mode = 1'b1;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata_o;
  logic          rvalid_o;

  nws_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .adv_i(adv), .we_ni(we_n), .bw_ni(bw_n),
    .ce1_ni(ce1_n), .ce2_i(ce2), .ce3_ni(ce3_n), .cke_ni(cke_n), .oe_ni(oe_n),
    .sleep_i(sleep), .mode_i(mode), .wdata_i(wdata), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  // ---------------- behavioural reference ----------------
  typedef struct {bit v; bit w; int a; bit [LN-1:0] bw;} op_t;
  op_t           pq[$];
  logic [DW-1:0] mm [DEPTH];
  bit            m_act, m_we, sh0, sh1, exp_rvq;
  int            m_start, m_k, m_up;
  logic [DW-1:0] exp_rd;

  always @(posedge clk or negedge rst_n) begin
    op_t od, nw;
    bit  asl;
    if (!rst_n) begin
      pq.delete();
      nw.v = 0; nw.w = 0; nw.a = 0; nw.bw = '1;
      pq.push_back(nw); pq.push_back(nw);
      for (int i = 0; i < DEPTH; i++) mm[i] = '0;
      m_act = 0; m_we = 0; sh0 = 0; sh1 = 0; exp_rvq = 0; exp_rd = '0;
      m_start = 0; m_k = 0; m_up = 0;
    end else begin
      asl = sh1;
      if (!cke_n) begin
        od = pq.pop_front();
        if (od.v && od.w) begin
          for (int l = 0; l < LN; l++)
            if (!od.bw[l]) mm[od.a][l*LW +: LW] = wdata[l*LW +: LW];
        end else if (od.v) exp_rd = mm[od.a];
        exp_rvq = od.v && !od.w;
        nw.v = 0; nw.w = 0; nw.a = 0; nw.bw = bw_n;
        if (asl) m_act = 0;
        else if (!adv) begin
          m_act = !ce1_n && ce2 && !ce3_n;
          if (m_act) begin
            m_we = !we_n; m_start = int'(addr) % 4; m_up = int'(addr) / 4; m_k = 0;
            nw.v = 1; nw.w = m_we; nw.a = int'(addr);
          end
        end else if (m_act) begin
          m_k = (m_k + 1) % 4;
          nw.v = 1; nw.w = m_we;
          nw.a = m_up * 4 + (mode ? (m_start ^ m_k) : ((m_start + m_k) % 4));
        end
        pq.push_back(nw);
      end
      sh1 = sh0; sh0 = sleep;
    end
  end

  // ---------------- checking ----------------
  int    tests = 0, fails = 0;
  string ph = "R11 reset";

  task automatic tick();
    bit ev;
    @(negedge clk);
    ev = exp_rvq && !oe_n && !sh1;
    tests++;
    if (rvalid_o !== ev) begin
      fails++;
      $display("FAIL %s: rvalid_o=%0b expected=%0b at %0t", ph, rvalid_o, ev, $time);
    end
    if (ev) begin
      tests++;
      if (rdata_o !== exp_rd) begin
        fails++;
        $display("FAIL %s: rdata_o=%h expected=%h at %0t", ph, rdata_o, exp_rd, $time);
      end
    end
  endtask

  task automatic rnd_data();
    logic [63:0] r;
    r = {$urandom, $urandom};
    wdata = r[DW-1:0];
  endtask

  task automatic cmd(bit a_adv, bit a_we_n, logic [LN-1:0] a_bw, int a_addr);
    adv = a_adv; we_n = a_we_n; bw_n = a_bw; addr = AW'(a_addr);
    ce1_n = 0; ce2 = 1; ce3_n = 0;
    rnd_data();
    tick();
  endtask

  task automatic idle(int n);
    repeat (n) begin
      adv = 0; ce1_n = 1; rnd_data();
      tick();
    end
  endtask

  task automatic burst(bit a_we_n, int a_addr, int n_adv);
    cmd(0, a_we_n, '0, a_addr);
    repeat (n_adv) cmd(1, 1, '0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, tests=%0d expected completion", tests);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    ph = "R11 reset state";
    idle(2);
    cmd(0, 1, '1, 5); cmd(0, 1, '1, 63); idle(3);

    ph = "R1 fill and alternate";
    for (int i = 0; i < DEPTH; i++) cmd(0, 0, '0, i);
    for (int i = 0; i < DEPTH; i++) cmd(0, i % 2 == 0, '0, i);
    for (int i = 0; i < DEPTH; i++) cmd(0, 1, '0, i);
    idle(3);

    ph = "R6 byte lanes";
    cmd(0, 0, 4'b1110, 10); cmd(0, 0, 4'b0101, 10); cmd(0, 0, 4'b1111, 10);
    cmd(0, 0, 4'b1111, 11); idle(1);
    cmd(0, 1, '1, 10); cmd(0, 1, '1, 11); idle(3);

    ph = "R7 read after write";
    cmd(0, 0, 4'b1100, 20); cmd(0, 1, '1, 20);
    cmd(0, 0, 4'b0011, 21); cmd(0, 1, '1, 21); cmd(0, 0, 4'b1001, 21);
    cmd(0, 1, '1, 21); idle(3);

    ph = "R4 interleaved bursts";
    mode = 1;
    for (int s = 0; s < 4; s++) burst(0, 32 + s, 3);
    for (int s = 0; s < 4; s++) burst(1, 32 + s, 3);
    idle(3);

    ph = "R5 linear bursts and wrap";
    mode = 0;
    for (int s = 0; s < 4; s++) burst(0, 40 + s, 3);
    for (int s = 0; s < 4; s++) burst(1, 40 + s, 6);
    mode = 1;
    burst(1, 33, 6);
    idle(3);

    ph = "R2 chip enables";
    for (int c = 1; c < 8; c++) begin
      adv = 0; we_n = 0; bw_n = '0; addr = AW'(50);
      ce1_n = c[0]; ce2 = !c[1]; ce3_n = c[2];
      rnd_data(); tick();
      adv = 0; we_n = 1; rnd_data(); tick();
    end
    cmd(0, 1, '1, 50); idle(3);

    ph = "R3 advance while deselected";
    idle(1);
    repeat (4) begin adv = 1; we_n = 0; bw_n = '0; ce1_n = 0; rnd_data(); tick(); end
    cmd(0, 1, '1, 0); cmd(0, 1, '1, 1); idle(3);

    ph = "R8 clock enable freeze";
    cmd(0, 1, '0, 44); cmd(1, 1, '0, 0);
    cke_n = 1;
    repeat (3) begin adv = 0; we_n = 0; bw_n = '0; addr = AW'(44); rnd_data(); tick(); end
    cke_n = 0;
    cmd(1, 1, '0, 0); cmd(0, 0, '0, 45);
    cke_n = 1; repeat (2) begin rnd_data(); tick(); end
    cke_n = 0;
    cmd(0, 1, '0, 45); idle(2); cmd(0, 1, '0, 44); idle(3);

    ph = "R9 output enable mask";
    burst(1, 12, 3);
    for (int i = 0; i < 6; i++) begin oe_n = i[0]; idle(1); end
    oe_n = 0; idle(2);

    ph = "R10 sleep entry and exit";
    burst(1, 16, 3);
    sleep = 1;
    cmd(0, 1, '1, 17); cmd(0, 1, '1, 18);
    repeat (4) cmd(0, 0, '0, 19);
    sleep = 0;
    cmd(0, 0, '0, 22); cmd(0, 1, '1, 23); cmd(0, 1, '1, 19); cmd(0, 1, '1, 22);
    idle(3);
    sleep = 1; cke_n = 1; idle(3); cke_n = 0; sleep = 0;
    idle(1); cmd(0, 1, '1, 19); idle(3);

    ph = "R1 random mix";
    for (int i = 0; i < 3000; i++) begin
      adv   = ($urandom % 3) == 0;
      we_n  = $urandom % 2;
      bw_n  = LN'($urandom);
      addr  = AW'($urandom);
      ce1_n = ($urandom % 6) == 0;
      ce2   = ($urandom % 6) != 0;
      ce3_n = ($urandom % 6) == 0;
      cke_n = ($urandom % 8) == 0;
      oe_n  = ($urandom % 8) == 0;
      if (($urandom % 64) == 0) sleep = !sleep;
      if (($urandom % 200) == 0) mode = !mode;
      rnd_data();
      tick();
    end
    cke_n = 0; oe_n = 0; sleep = 0;
    idle(4);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule